// File: doc/BRIEF.md
# Asynchronous memory bank decoder

This block sits between a processor's register bus and an external asynchronous memory port. Software sees three registers: one global control word and two bank-control words. A three-bit field in the global control word says how many of up to four equal external banks are switched on. The bank-control words hold timing settings that this block only stores and returns on read.

On the memory side, each incoming external address is matched against the bank windows. The windows follow one another from a fixed base, each one bank-size long. An address inside an enabled window produces a one-hot select for that bank's downstream slave. An address in a disabled window, or outside every window, raises a decode-error flag and selects no bank.

Register accesses carry a size code and are checked first for width and then for offset. The result is a registered response: an acknowledge pulse, together with read data and two error flags.

Top module: `xmem_bank_ctl`

## Requirements
- R1: The enabled-bank count is bits 3:1 of the global control word, clamped to 4 when the field is 5, 6 or 7. Bank i is enabled exactly when i is less than that count, so a field of 0 disables every bank.
- R2: Bank i covers the addresses from BANK_BASE + i*2^BANK_LOG2 up to the next window; defaults are BANK_BASE 0x2000_0000 and BANK_LOG2 20. For each accepted external access, `ext_rsp_valid` goes high one cycle after `ext_valid`. If the address is in an enabled bank i, `ext_sel` is 1<<i and `ext_dec_err` is 0.
- R3: For an external address in a disabled bank, below BANK_BASE, or at or above BANK_BASE + NUM_BANKS*2^BANK_LOG2, the response has `ext_dec_err`=1 and `ext_sel`=0.
- R4: After reset the global control word reads 0x00F2, which gives a count of 1, and both bank-control words read 0xFFC2FFC2.
- R5: `reg_size` codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. Only codes 1 and 2 are legal; any other code raises `reg_err_width`.
- R6: The global control word is at offset 0x0 and accepts only 16-bit accesses. A 32-bit access to it raises `reg_err_width` and changes nothing. A write stores `reg_wdata[15:0]`, and a read returns the word zero-extended to 32 bits.
- R7: The bank-control words are at offsets 0x4 and 0x8. A 32-bit write stores all 32 bits. A 16-bit write replaces bits 15:0 and keeps bits 31:16. A read returns all 32 bits at either width.
- R8: A width violation takes priority over an unmapped offset: in that case only `reg_err_width` is raised and `reg_err_offset` stays 0.
- R9: A legal-width access to any offset other than 0x0, 0x4 and 0x8 raises `reg_err_offset`, writes nothing, and returns read data 0.
- R10: `reg_ack` pulses for exactly one cycle, one cycle after a `reg_req` cycle. The error flags are high only during that pulse, and any errored access returns read data 0.
- R11: A global control write changes the decode for external accesses sampled on the clock edge after the write's request edge. An external access sampled on the same edge as the write still uses the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_size | input | 2 | Access size code (0=8, 1=16, 2=32, 3=64 bits) |
| reg_off | input | REG_AW (4) | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_ack | output | 1 | Access acknowledge pulse |
| reg_rdata | output | 32 | Read data, valid with reg_ack |
| reg_err_width | output | 1 | Access width error, with reg_ack |
| reg_err_offset | output | 1 | Unmapped offset error, with reg_ack |
| ext_valid | input | 1 | External access strobe |
| ext_addr | input | ADDR_W (32) | External access address |
| ext_rsp_valid | output | 1 | Decode result valid |
| ext_sel | output | NUM_BANKS (4) | One-hot bank select |
| ext_dec_err | output | 1 | Access to disabled or unmapped bank |

## Verification
The bench walks the clamp on the count field with values 0, 2, 4 and 7. A decoder that did not saturate would wrap 7 into a bogus count or light bank selects that do not exist. It tests addresses one byte below the base and exactly at the end of the last window. An off-by-one window compare would select a bank there instead of flagging an error. It sends illegal widths to an unmapped offset and 32-bit accesses to the global word. A wrong priority would raise both flags or only the offset flag, and a missing per-register check would let the 32-bit write land. Finally, it issues an external access on the same edge as a global control write. A design that decoded straight from the incoming write data would use the new count one edge too early.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

   typedef enum logic [1:0] {
      SZ_8  = 2'd0,
      SZ_16 = 2'd1,
      SZ_32 = 2'd2,
      SZ_64 = 2'd3
   } xmb_size_e;

   typedef enum logic [1:0] {
      ACC_OK         = 2'd0,
      ACC_BAD_WIDTH  = 2'd1,
      ACC_BAD_OFFSET = 2'd2
   } xmb_acc_e;

   typedef enum logic [1:0] {
      TGT_GLB   = 2'd0,
      TGT_BANK0 = 2'd1,
      TGT_BANK1 = 2'd2,
      TGT_NONE  = 2'd3
   } xmb_tgt_e;

   localparam int unsigned OFF_GLB   = 0;
   localparam int unsigned OFF_BANK0 = 4;
   localparam int unsigned OFF_BANK1 = 8;

   localparam int unsigned MAX_BANKS = 4;
   localparam int unsigned CNT_W     = 3;

   localparam logic [15:0] GLB_RST  = 16'h00F2;
   localparam logic [31:0] BCTL_RST = 32'hFFC2_FFC2;

   function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] field);
      if (field > CNT_W'(MAX_BANKS))
         return CNT_W'(MAX_BANKS);
      return field;
   endfunction

endpackage

// File: rtl/xmb_access_chk.sv
module xmb_access_chk
   import xmb_pkg::*;
#(
   parameter int unsigned REG_AW = 4
)(
   input  logic [1:0]        req_size,
   input  logic [REG_AW-1:0] req_off,
   output xmb_tgt_e          tgt,
   output xmb_acc_e          status
);

   if (REG_AW < 4) begin : g_bad_aw
      $error("xmb_access_chk: REG_AW must be at least 4");
   end

   logic width_legal;
   logic glb_width_ok;

   always_comb begin
      if (req_off == REG_AW'(OFF_GLB))
         tgt = TGT_GLB;
      else if (req_off == REG_AW'(OFF_BANK0))
         tgt = TGT_BANK0;
      else if (req_off == REG_AW'(OFF_BANK1))
         tgt = TGT_BANK1;
      else
         tgt = TGT_NONE;
   end

   assign width_legal  = (req_size == SZ_16) || (req_size == SZ_32);
   assign glb_width_ok = (req_size == SZ_16);

   // Width faults are ranked above the offset fault.
   always_comb begin
      if (!width_legal)
         status = ACC_BAD_WIDTH;
      else if (tgt == TGT_GLB && !glb_width_ok)
         status = ACC_BAD_WIDTH;
      else if (tgt == TGT_NONE)
         status = ACC_BAD_OFFSET;
      else
         status = ACC_OK;
   end

endmodule

// File: rtl/xmb_regfile.sv
module xmb_regfile
   import xmb_pkg::*;
#(
   parameter int unsigned DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wr,
   input  logic [1:0]        size,
   input  xmb_tgt_e          tgt,
   input  xmb_acc_e          status,
   input  logic [DATA_W-1:0] wdata,
   output logic              ack,
   output logic [DATA_W-1:0] rdata,
   output logic              err_width,
   output logic              err_offset,
   output logic [15:0]       glb_word
);

   if (DATA_W != 32) begin : g_bad_dw
      $error("xmb_regfile: DATA_W must be 32");
   end

   localparam int unsigned NUM_BCTL = 2;
   localparam int unsigned HALF_W   = DATA_W / 2;

   logic [15:0]                     glb_q;
   logic [NUM_BCTL-1:0][DATA_W-1:0] bctl_q;
   logic                            ack_q;
   logic                            errw_q;
   logic                            erro_q;
   logic [DATA_W-1:0]               rdata_q;

   logic              acc_ok;
   logic              wr_en;
   logic [DATA_W-1:0] rd_mux;

   assign acc_ok = req && (status == ACC_OK);
   assign wr_en  = acc_ok && wr;

   always_comb begin
      case (tgt)
         TGT_GLB:   rd_mux = DATA_W'(glb_q);
         TGT_BANK0: rd_mux = bctl_q[0];
         TGT_BANK1: rd_mux = bctl_q[1];
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glb_q <= GLB_RST;
         for (int i = 0; i < NUM_BCTL; i++)
            bctl_q[i] <= BCTL_RST;
      end else if (wr_en) begin
         if (tgt == TGT_GLB)
            glb_q <= wdata[15:0];
         for (int i = 0; i < NUM_BCTL; i++) begin
            if (int'(tgt) == i + 1) begin
               if (size == SZ_32)
                  bctl_q[i] <= wdata;
               else
                  bctl_q[i][HALF_W-1:0] <= wdata[HALF_W-1:0];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         errw_q  <= 1'b0;
         erro_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q   <= req;
         errw_q  <= req && (status == ACC_BAD_WIDTH);
         erro_q  <= req && (status == ACC_BAD_OFFSET);
         rdata_q <= (acc_ok && !wr) ? rd_mux : '0;
      end
   end

   assign ack        = ack_q;
   assign err_width  = errw_q;
   assign err_offset = erro_q;
   assign rdata      = rdata_q;
   assign glb_word   = glb_q;

   assert_one_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_width && err_offset));

   assert_err_with_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_width || err_offset) |-> ack);

   assert_err_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_width || err_offset) |-> (rdata == '0));

   assert_err_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req && status != ACC_OK) |=> ($stable(glb_q) && $stable(bctl_q)));

   assert_glb_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && tgt == TGT_GLB && size == SZ_32) |=> err_width);

endmodule

// File: rtl/xmb_bank_map.sv
module xmb_bank_map
   import xmb_pkg::*;
#(
   parameter int unsigned        ADDR_W    = 32,
   parameter int unsigned        NUM_BANKS = 4,
   parameter int unsigned        BANK_LOG2 = 20,
   parameter logic [ADDR_W-1:0]  BANK_BASE = 32'h2000_0000,
   parameter bit                 OUT_REG   = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CNT_W-1:0]     cnt_field,
   input  logic                 ext_valid,
   input  logic [ADDR_W-1:0]    ext_addr,
   output logic                 ext_rsp_valid,
   output logic [NUM_BANKS-1:0] ext_sel,
   output logic                 ext_dec_err
);

   localparam logic [63:0] BANK_SPAN = 64'd1 << BANK_LOG2;
   localparam logic [63:0] BASE64    = 64'(BANK_BASE);

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_nb
      $error("xmb_bank_map: NUM_BANKS must be 1 to 4");
   end
   if (BANK_LOG2 != 20 && BANK_LOG2 != 26) begin : g_bad_sz
      $error("xmb_bank_map: BANK_LOG2 must be 20 or 26");
   end
   if ((BASE64 % BANK_SPAN) != 64'd0) begin : g_bad_base
      $error("xmb_bank_map: BANK_BASE must be bank aligned");
   end
   if (BASE64 + 64'(NUM_BANKS) * BANK_SPAN > (64'd1 << ADDR_W)) begin : g_bad_top
      $error("xmb_bank_map: bank windows exceed the address space");
   end

   logic [CNT_W-1:0]     en_cnt;
   logic [63:0]          addr64;
   logic [NUM_BANKS-1:0] hit;
   logic [NUM_BANKS-1:0] sel_c;
   logic                 err_c;

   assign en_cnt = clamp_count(cnt_field);
   assign addr64 = 64'(ext_addr);

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      localparam logic [63:0] LO = BASE64 + 64'(i) * BANK_SPAN;
      localparam logic [63:0] HI = LO + BANK_SPAN;
      logic enabled;
      assign enabled  = (CNT_W'(i) < en_cnt);
      assign hit[i]   = (addr64 >= LO) && (addr64 < HI);
      assign sel_c[i] = ext_valid && hit[i] && enabled;
   end

   assign err_c = ext_valid && (sel_c == '0);

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ext_rsp_valid <= 1'b0;
            ext_sel       <= '0;
            ext_dec_err   <= 1'b0;
         end else begin
            ext_rsp_valid <= ext_valid;
            ext_sel       <= sel_c;
            ext_dec_err   <= err_c;
         end
      end
   end else begin : g_comb_out
      assign ext_rsp_valid = ext_valid;
      assign ext_sel       = sel_c;
      assign ext_dec_err   = err_c;
   end

   assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ext_sel));

   assert_err_no_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ext_dec_err |-> (ext_sel == '0));

   assert_rsp_covers_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rsp_valid |-> ($countones(ext_sel) + int'(ext_dec_err) == 1));

   assert_cnt_sat_R1: assert property (@(posedge clk) disable iff (!rst_n)
      en_cnt <= CNT_W'(MAX_BANKS));

endmodule

// File: rtl/xmem_bank_ctl.sv
module xmem_bank_ctl
   import xmb_pkg::*;
#(
   parameter int unsigned       REG_AW    = 4,
   parameter int unsigned       ADDR_W    = 32,
   parameter int unsigned       NUM_BANKS = 4,
   parameter int unsigned       BANK_LOG2 = 20,
   parameter logic [ADDR_W-1:0] BANK_BASE = 32'h2000_0000,
   parameter bit                OUT_REG   = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_req,
   input  logic                 reg_wr,
   input  logic [1:0]           reg_size,
   input  logic [REG_AW-1:0]    reg_off,
   input  logic [31:0]          reg_wdata,
   output logic                 reg_ack,
   output logic [31:0]          reg_rdata,
   output logic                 reg_err_width,
   output logic                 reg_err_offset,
   input  logic                 ext_valid,
   input  logic [ADDR_W-1:0]    ext_addr,
   output logic                 ext_rsp_valid,
   output logic [NUM_BANKS-1:0] ext_sel,
   output logic                 ext_dec_err
);

   xmb_tgt_e    tgt;
   xmb_acc_e    status;
   logic [15:0] glb_word;

   xmb_access_chk #(
      .REG_AW (REG_AW)
   ) u_chk (
      .req_size (reg_size),
      .req_off  (reg_off),
      .tgt      (tgt),
      .status   (status)
   );

   xmb_regfile #(
      .DATA_W (32)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (reg_req),
      .wr         (reg_wr),
      .size       (reg_size),
      .tgt        (tgt),
      .status     (status),
      .wdata      (reg_wdata),
      .ack        (reg_ack),
      .rdata      (reg_rdata),
      .err_width  (reg_err_width),
      .err_offset (reg_err_offset),
      .glb_word   (glb_word)
   );

   xmb_bank_map #(
      .ADDR_W    (ADDR_W),
      .NUM_BANKS (NUM_BANKS),
      .BANK_LOG2 (BANK_LOG2),
      .BANK_BASE (BANK_BASE),
      .OUT_REG   (OUT_REG)
   ) u_map (
      .clk           (clk),
      .rst_n         (rst_n),
      .cnt_field     (glb_word[3:1]),
      .ext_valid     (ext_valid),
      .ext_addr      (ext_addr),
      .ext_rsp_valid (ext_rsp_valid),
      .ext_sel       (ext_sel),
      .ext_dec_err   (ext_dec_err)
   );

endmodule

// File: tb/sim_xmem_bank_ctl.sv
module sim_xmem_bank_ctl;

   localparam logic [31:0] BASE = 32'h2000_0000;
   localparam logic [31:0] SPAN = 32'h0010_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_req = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_size = 2'd1;
   logic [3:0]  reg_off = 4'd0;
   logic [31:0] reg_wdata = '0;
   logic        reg_ack;
   logic [31:0] reg_rdata;
   logic        reg_err_width;
   logic        reg_err_offset;
   logic        ext_valid = 1'b0;
   logic [31:0] ext_addr = '0;
   logic        ext_rsp_valid;
   logic [3:0]  ext_sel;
   logic        ext_dec_err;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   xmem_bank_ctl u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_req(reg_req), .reg_wr(reg_wr), .reg_size(reg_size), .reg_off(reg_off),
      .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
      .reg_err_width(reg_err_width), .reg_err_offset(reg_err_offset),
      .ext_valid(ext_valid), .ext_addr(ext_addr), .ext_rsp_valid(ext_rsp_valid),
      .ext_sel(ext_sel), .ext_dec_err(ext_dec_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // One register access; checks ack, flags, read data and the ack drop.
   task automatic reg_op(input string tag, input logic wr, input logic [1:0] sz,
                         input logic [3:0] off, input logic [31:0] wd,
                         input logic ew, input logic eo, input logic [31:0] rd_exp);
      @(negedge clk);
      reg_req = 1'b1; reg_wr = wr; reg_size = sz; reg_off = off; reg_wdata = wd;
      @(negedge clk);
      reg_req = 1'b0;
      chk({tag, " ack R10"}, 32'(reg_ack), 32'd1);
      chk({tag, " width flag"}, 32'(reg_err_width), 32'(ew));
      chk({tag, " offset flag"}, 32'(reg_err_offset), 32'(eo));
      if (!wr) chk({tag, " rdata"}, reg_rdata, rd_exp);
      @(negedge clk);
      chk({tag, " ack pulse R10"}, {29'd0, reg_ack, reg_err_width, reg_err_offset}, 32'd0);
   endtask

   task automatic ext_op(input string tag, input logic [31:0] addr,
                         input logic [3:0] sel_exp, input logic err_exp);
      @(negedge clk);
      ext_valid = 1'b1; ext_addr = addr;
      @(negedge clk);
      ext_valid = 1'b0;
      chk({tag, " rsp_valid"}, 32'(ext_rsp_valid), 32'd1);
      chk({tag, " sel"}, 32'(ext_sel), 32'(sel_exp));
      chk({tag, " dec_err"}, 32'(ext_dec_err), 32'(err_exp));
   endtask

   task automatic t_reset;
      chk("reset ack idle R10", {30'd0, reg_ack, ext_rsp_valid}, 32'd0);
      reg_op("R4 glb reset", 1'b0, 2'd1, 4'h0, 0, 1'b0, 1'b0, 32'h0000_00F2);
      reg_op("R4 bank0 reset", 1'b0, 2'd2, 4'h4, 0, 1'b0, 1'b0, 32'hFFC2_FFC2);
      reg_op("R4 bank1 reset", 1'b0, 2'd2, 4'h8, 0, 1'b0, 1'b0, 32'hFFC2_FFC2);
      ext_op("R1 reset bank0 on", BASE + 32'h10, 4'b0001, 1'b0);
      ext_op("R1 reset bank1 off", BASE + SPAN, 4'b0000, 1'b1);
   endtask

   task automatic t_width;
      reg_op("R5 8-bit read", 1'b0, 2'd0, 4'h4, 0, 1'b1, 1'b0, 32'h0);
      reg_op("R5 64-bit read", 1'b0, 2'd3, 4'h8, 0, 1'b1, 1'b0, 32'h0);
      reg_op("R5 8-bit write", 1'b1, 2'd0, 4'h4, 32'h1111_1111, 1'b1, 1'b0, 0);
      reg_op("R5 bank0 kept", 1'b0, 2'd2, 4'h4, 0, 1'b0, 1'b0, 32'hFFC2_FFC2);
      reg_op("R6 glb 32 read", 1'b0, 2'd2, 4'h0, 0, 1'b1, 1'b0, 32'h0);
      reg_op("R6 glb 32 write", 1'b1, 2'd2, 4'h0, 32'h0000_0008, 1'b1, 1'b0, 0);
      reg_op("R6 glb kept", 1'b0, 2'd1, 4'h0, 0, 1'b0, 1'b0, 32'h0000_00F2);
   endtask

   task automatic t_priority;
      reg_op("R8 8-bit unmapped", 1'b0, 2'd0, 4'hC, 0, 1'b1, 1'b0, 32'h0);
      reg_op("R8 64-bit unmapped wr", 1'b1, 2'd3, 4'h2, 32'h5, 1'b1, 1'b0, 0);
   endtask

   task automatic t_offset;
      reg_op("R9 write 0xC", 1'b1, 2'd1, 4'hC, 32'h0000_0008, 1'b0, 1'b1, 0);
      reg_op("R9 read 0x2", 1'b0, 2'd2, 4'h2, 0, 1'b0, 1'b1, 32'h0);
      reg_op("R9 write 0x6", 1'b1, 2'd2, 4'h6, 32'h0BAD_0BAD, 1'b0, 1'b1, 0);
      reg_op("R9 glb kept", 1'b0, 2'd1, 4'h0, 0, 1'b0, 1'b0, 32'h0000_00F2);
      reg_op("R9 bank0 kept", 1'b0, 2'd2, 4'h4, 0, 1'b0, 1'b0, 32'hFFC2_FFC2);
   endtask

   task automatic t_bankctl;
      reg_op("R7 wr32 bank0", 1'b1, 2'd2, 4'h4, 32'h1234_5678, 1'b0, 1'b0, 0);
      reg_op("R7 rd32 bank0", 1'b0, 2'd2, 4'h4, 0, 1'b0, 1'b0, 32'h1234_5678);
      reg_op("R7 wr16 bank1", 1'b1, 2'd1, 4'h8, 32'h9999_ABCD, 1'b0, 1'b0, 0);
      reg_op("R7 rd16 bank1", 1'b0, 2'd1, 4'h8, 0, 1'b0, 1'b0, 32'hFFC2_ABCD);
   endtask

   task automatic t_decode;
      reg_op("R6 glb write 4", 1'b1, 2'd1, 4'h0, 32'hABCD_0008, 1'b0, 1'b0, 0);
      reg_op("R6 glb readback", 1'b0, 2'd1, 4'h0, 0, 1'b0, 1'b0, 32'h0000_0008);
      for (int i = 0; i < 4; i++) begin
         ext_op($sformatf("R2 bank%0d start", i), BASE + SPAN * i, 4'(1 << i), 1'b0);
         ext_op($sformatf("R2 bank%0d end", i), BASE + SPAN * (i + 1) - 1, 4'(1 << i), 1'b0);
      end
      ext_op("R3 below base", BASE - 1, 4'b0000, 1'b1);
      ext_op("R3 past last", BASE + SPAN * 4, 4'b0000, 1'b1);
   endtask

   task automatic t_saturate;
      reg_op("R1 field 7", 1'b1, 2'd1, 4'h0, 32'h0000_000E, 1'b0, 1'b0, 0);
      ext_op("R1 field 7 bank3", BASE + SPAN * 3, 4'b1000, 1'b0);
      ext_op("R1 field 7 past", BASE + SPAN * 4, 4'b0000, 1'b1);
      reg_op("R1 field 2", 1'b1, 2'd1, 4'h0, 32'h0000_0004, 1'b0, 1'b0, 0);
      ext_op("R1 field 2 bank1", BASE + SPAN + 32'h40, 4'b0010, 1'b0);
      ext_op("R3 field 2 bank2", BASE + SPAN * 2, 4'b0000, 1'b1);
      reg_op("R1 field 0", 1'b1, 2'd1, 4'h0, 32'h0000_00F0, 1'b0, 1'b0, 0);
      ext_op("R1 field 0 bank0", BASE, 4'b0000, 1'b1);
   endtask

   task automatic t_timing;
      reg_op("R11 setup field 4", 1'b1, 2'd1, 4'h0, 32'h0000_0008, 1'b0, 1'b0, 0);
      // Write count 1 and decode bank 2 on the same edge: old count applies.
      @(negedge clk);
      reg_req = 1'b1; reg_wr = 1'b1; reg_size = 2'd1; reg_off = 4'h0; reg_wdata = 32'h0000_0002;
      ext_valid = 1'b1; ext_addr = BASE + SPAN * 2;
      @(negedge clk);
      reg_req = 1'b0;
      chk("R11 same-edge ack", 32'(reg_ack), 32'd1);
      chk("R11 same-edge sel", 32'(ext_sel), 32'b0100);
      chk("R11 same-edge err", 32'(ext_dec_err), 32'd0);
      // ext_valid stays high: this edge sees the new count.
      @(negedge clk);
      ext_valid = 1'b0;
      chk("R11 next-edge sel", 32'(ext_sel), 32'b0000);
      chk("R11 next-edge err", 32'(ext_dec_err), 32'd1);
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_width();
      t_priority();
      t_offset();
      t_bankctl();
      t_decode();
      t_saturate();
      t_timing();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule